// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Drive Controller

This block turns a single PWM command into two complementary gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. When the block is enabled, the high-side enable follows PWM and the low-side enable is its inverse. Every hand-over between the two switches passes through a dead-time sequence, so the two enables are never high together.

When the high side turns off, the block watches a flag that says the switch node is under about 1 V. It turns the low side on once the node has first been seen high and has then dropped below that level. If the node never went high, the low side turns on after a fixed delay. If the node stays high too long, a timeout turns the low side on anyway. When the low side turns off, the block waits for a flag that says the low-side gate has discharged, then adds a programmable delay before it turns the high side on.

An active-low disable input forces both enables low at once. When the disable is released, the block re-enters through the same dead-time path that the present PWM level calls for. Each of the four asynchronous inputs passes through a synchronizer before the sequencer uses it. All delays are counted in clock cycles.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: With the block enabled and the inputs settled, `hs_en` equals `pwm_in` and `ls_en` equals the inverse of `pwm_in`. A PWM edge turns off the enable that is currently on at the third rising clock edge after the input changes.
- R2: While `out_en_n` is 0, `hs_en` and `ls_en` are both 0 in the same cycle, with no clock edge needed and whatever the PWM level.
- R3: `hs_en` and `ls_en` are never 1 at the same time, and each one rises only after the other was 0 in the previous cycle.
- R4: If `sw_low` (1 = switch node below 1 V) stays 1 throughout the wait after `hs_en` falls, `ls_en` rises FALLBACK_CYC cycles after `hs_en` falls. The default is 15.
- R5: If `sw_low` goes to 0 for H cycles (1 ≤ H ≤ 15) starting at the sample where `hs_en` is first seen low, `ls_en` rises H+3 cycles after `hs_en` falls. That is, it rises on the third clock edge after `sw_low` returns to 1.
- R6: If the switch node has not dropped back below 1 V, `ls_en` rises TIMEOUT_CYC cycles after `hs_en` falls. The default is 19. The wait never lasts longer than this.
- R7: After `ls_en` falls, `hs_en` rises HS_DLY_CYC cycles after the synchronized `lsg_low` flag (1 = low-side gate below one sixth of the supply) is seen. If `lsg_low` rises L cycles after `ls_en` falls, the gap is L+3+HS_DLY_CYC cycles. The default HS_DLY_CYC is 3.
- R8: If PWM reverses during a dead-time wait, the pending turn-on is dropped and the opposite sequence starts. If PWM rises P cycles into the low-side wait, `hs_en` rises P+4+HS_DLY_CYC cycles after `hs_en` fell, and `ls_en` stays 0. If PWM falls P cycles into the high-side wait, `ls_en` rises P+18 cycles after `ls_en` fell, through the fallback path with no switch-node rise, and `hs_en` stays 0.
- R9: When `out_en_n` is released with PWM high and `lsg_low` at 1, `hs_en` rises 4+HS_DLY_CYC cycles later. When it is released with PWM low and `sw_low` at 1, `ls_en` rises 18 cycles later. In both cases the other enable stays 0.
- R10: While `rst_n` is 0, both enables are 0 and the record that the switch node was seen high is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| out_en_n | input | 1 | Active-low output disable, asynchronous |
| sw_low | input | 1 | Comparator flag: switch node below about 1 V |
| lsg_low | input | 1 | Comparator flag: low-side gate below one sixth of supply |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The assertions check the following on every cycle:
- the two enables never overlap;
- each enable rises only after the other was already low;
- both enables stay low while the disable input is low;
- the low-side wait never runs past the timeout.

The exact dead-time lengths can only be shown by the bench's scenarios. These cover the fallback, the node-fall and the timeout paths, the gate-discharge delay, the PWM reversals during a wait, and the restart after the disable is released. The bench drives each of these with measured cycle counts against expected gaps it computes itself.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_HS_ON   = 3'd1,
      ST_LS_WAIT = 3'd2,
      ST_LS_ON   = 3'd3,
      ST_HS_GATE = 3'd4,
      ST_HS_DLY  = 3'd5
   } gdt_state_t;

   // bit positions inside the synchronizer bundle
   localparam int unsigned SB_PWM = 0;
   localparam int unsigned SB_EN  = 1;
   localparam int unsigned SB_SWL = 2;
   localparam int unsigned SB_LSG = 3;
   localparam int unsigned SB_W   = 4;

endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/gdt_counter.sv
module gdt_counter #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/gdt_fsm.sv
module gdt_fsm
   import gdt_pkg::*;
#(
   parameter int unsigned CW = 5,
   parameter int unsigned FALLBACK_CYC = 15,
   parameter int unsigned TIMEOUT_CYC = 19,
   parameter int unsigned HS_DLY_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwm_s,
   input  logic          en_s,
   input  logic          swl_s,
   input  logic          lsg_s,
   input  logic [CW-1:0] cnt_q,
   output logic          cnt_clr,
   output logic          hs_q,
   output logic          ls_q,
   output logic          ls_wait
);

   localparam logic [CW-1:0] FB_LAST  = CW'(FALLBACK_CYC - 1);
   localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);
   localparam logic [CW-1:0] DLY_LAST = CW'(HS_DLY_CYC - 1);

   gdt_state_t st_q, st_d;
   logic       seen_q, seen_d;
   logic       node_fell, fb_hit, to_hit;

   assign node_fell = seen_q && swl_s;
   assign fb_hit    = !seen_q && swl_s && (cnt_q == FB_LAST);
   assign to_hit    = (cnt_q == TO_LAST);

   always_comb begin
      st_d    = st_q;
      seen_d  = seen_q;
      cnt_clr = 1'b0;
      if (!en_s) begin
         st_d    = ST_IDLE;
         seen_d  = 1'b0;
         cnt_clr = 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               st_d    = pwm_s ? ST_HS_GATE : ST_LS_WAIT;
               seen_d  = 1'b0;
               cnt_clr = 1'b1;
            end
            ST_HS_ON: begin
               if (!pwm_s) begin
                  st_d    = ST_LS_WAIT;
                  seen_d  = 1'b0;
                  cnt_clr = 1'b1;
               end
            end
            ST_LS_WAIT: begin
               if (pwm_s) begin
                  st_d    = ST_HS_GATE;
                  cnt_clr = 1'b1;
               end else begin
                  seen_d = seen_q | !swl_s;
                  if (node_fell || fb_hit || to_hit) st_d = ST_LS_ON;
               end
            end
            ST_LS_ON: begin
               if (pwm_s) begin
                  st_d    = ST_HS_GATE;
                  cnt_clr = 1'b1;
               end
            end
            ST_HS_GATE: begin
               if (!pwm_s) begin
                  st_d    = ST_LS_WAIT;
                  seen_d  = 1'b0;
                  cnt_clr = 1'b1;
               end else if (lsg_s) begin
                  st_d    = ST_HS_DLY;
                  cnt_clr = 1'b1;
               end
            end
            ST_HS_DLY: begin
               if (!pwm_s) begin
                  st_d    = ST_LS_WAIT;
                  seen_d  = 1'b0;
                  cnt_clr = 1'b1;
               end else if (cnt_q == DLY_LAST) begin
                  st_d = ST_HS_ON;
               end
            end
            default: begin
               st_d    = ST_IDLE;
               seen_d  = 1'b0;
               cnt_clr = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         seen_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         seen_q <= seen_d;
      end
   end

   assign hs_q    = (st_q == ST_HS_ON);
   assign ls_q    = (st_q == ST_LS_ON);
   assign ls_wait = (st_q == ST_LS_WAIT);

endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
   import gdt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FALLBACK_CYC = 15,
   parameter int unsigned TIMEOUT_CYC = 19,
   parameter int unsigned HS_DLY_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic out_en_n,
   input  logic sw_low,
   input  logic lsg_low,
   output logic hs_en,
   output logic ls_en
);

   localparam int unsigned CNT_TOP = (TIMEOUT_CYC > HS_DLY_CYC) ? TIMEOUT_CYC : HS_DLY_CYC;
   localparam int unsigned CW = $clog2(CNT_TOP + 1);
   localparam logic [SB_W-1:0] SYNC_RST = SB_W'(1) << SB_SWL;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FALLBACK_CYC < 2 || FALLBACK_CYC >= TIMEOUT_CYC) begin : g_bad_fb
      $error("FALLBACK_CYC must be at least 2 and below TIMEOUT_CYC");
   end
   if (HS_DLY_CYC < 1) begin : g_bad_dly
      $error("HS_DLY_CYC must be at least 1");
   end

   logic [SB_W-1:0] raw_in, syn;
   logic [CW-1:0]   cnt_q;
   logic            cnt_clr, hs_q, ls_q, ls_wait_w;

   always_comb begin
      raw_in         = '0;
      raw_in[SB_PWM] = pwm_in;
      raw_in[SB_EN]  = out_en_n;
      raw_in[SB_SWL] = sw_low;
      raw_in[SB_LSG] = lsg_low;
   end

   gdt_sync #(
      .WIDTH(SB_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(syn)
   );

   gdt_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt_q)
   );

   gdt_fsm #(
      .CW(CW), .FALLBACK_CYC(FALLBACK_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC), .HS_DLY_CYC(HS_DLY_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .pwm_s(syn[SB_PWM]), .en_s(syn[SB_EN]),
      .swl_s(syn[SB_SWL]), .lsg_s(syn[SB_LSG]),
      .cnt_q(cnt_q), .cnt_clr(cnt_clr),
      .hs_q(hs_q), .ls_q(ls_q), .ls_wait(ls_wait_w)
   );

   // the raw disable pin gates the registered enables, so turn-off needs no clock edge
   assign hs_en = hs_q & out_en_n;
   assign ls_en = ls_q & out_en_n;

endmodule

// File: rtl/gdt_checker.sv
module gdt_checker #(
   parameter int unsigned TIMEOUT_CYC = 19
) (
   input logic clk,
   input logic rst_n,
   input logic out_en_n,
   input logic hs_en,
   input logic ls_en,
   input logic ls_wait
);

   localparam int unsigned KW = $clog2(TIMEOUT_CYC + 2);
   logic [KW-1:0] wait_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wait_len <= '0;
      else if (!ls_wait)                   wait_len <= '0;
      else if (wait_len != KW'(TIMEOUT_CYC + 1)) wait_len <= wait_len + 1'b1;
   end

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   assert_ls_after_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> $past(!hs_en));

   assert_hs_after_ls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(!ls_en));

   assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_n |-> (!hs_en && !ls_en));

   assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wait_len <= KW'(TIMEOUT_CYC));

endmodule

bind gate_deadtime_ctrl gdt_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n),
   .hs_en(hs_en), .ls_en(ls_en), .ls_wait(ls_wait_w)
);

// File: tb/sim_gate_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_gate_deadtime_ctrl;

   localparam int FB = 15;
   localparam int TO = 19;
   localparam int DLY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_in = 1'b0;
   logic out_en_n = 1'b1;
   logic sw_low = 1'b1;
   logic lsg_low = 1'b1;
   logic hs_en, ls_en;

   int tests = 0;
   int fails = 0;
   bit overlap = 1'b0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   gate_deadtime_ctrl #(
      .SYNC_STAGES(2), .FALLBACK_CYC(FB), .TIMEOUT_CYC(TO), .HS_DLY_CYC(DLY)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .out_en_n(out_en_n),
      .sw_low(sw_low), .lsg_low(lsg_low), .hs_en(hs_en), .ls_en(ls_en)
   );

   always @(negedge clk) if (hs_en && ls_en) overlap = 1'b1;

   function automatic int exp_lo_gap(int h);
      int g;
      if (h == 0) return FB;
      g = h + 3;
      if (g < 4) g = 4;
      return (g > TO) ? TO : g;
   endfunction

   function automatic int exp_hi_gap(int l);
      return l + 3 + DLY;
   endfunction

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         chk("R3 overlap seen", int'(overlap), 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   // low-side entry: switch node low flag dropped for h cycles after hs falls
   task automatic lo_cycle(int h, string req);
      int gap = 0;
      int w = 0;
      @(negedge clk) pwm_in = 1'b0;
      while (hs_en && w < 10) begin @(negedge clk); w++; end
      if (h > 0) sw_low = 1'b0;
      while (!ls_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (gap == h) sw_low = 1'b1;
      end
      sw_low = 1'b1;
      lsg_low = 1'b0;
      chk(req, gap, exp_lo_gap(h));
   endtask

   // high-side entry: gate-low flag rises l cycles after ls falls
   task automatic hi_cycle(int l, string req);
      int gap = 0;
      int w = 0;
      @(negedge clk) pwm_in = 1'b1;
      while (ls_en && w < 10) begin @(negedge clk); w++; end
      if (l == 0) lsg_low = 1'b1;
      while (!hs_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (gap == l) lsg_low = 1'b1;
      end
      lsg_low = 1'b1;
      chk(req, gap, exp_hi_gap(l));
   endtask

   initial begin
      hold(150000);
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int gap, w;
      bit other;
      void'($urandom(32'd20240611));

      // R10: reset state
      hold(3);
      chk("R10 hs in reset", int'(hs_en), 0);
      chk("R10 ls in reset", int'(ls_en), 0);
      @(negedge clk) rst_n = 1'b1;
      w = 0;
      while (!ls_en && w < 40) begin @(negedge clk); w++; end
      chk("R1 ls on after reset", int'(ls_en), 1);
      lsg_low = 1'b0;
      hold(10);

      // directed dead-time paths
      hi_cycle(0, "R7 gate already low");
      hold(12);
      chk("R1 steady hs", int'(hs_en), 1);
      chk("R1 steady ls", int'(ls_en), 0);
      lo_cycle(0, "R4 fallback");
      hold(12);
      chk("R1 steady ls low pwm", int'(ls_en), 1);
      chk("R1 steady hs low pwm", int'(hs_en), 0);
      hi_cycle(5, "R7 gate late");
      hold(10);
      lo_cycle(1, "R5 short node rise");
      hold(10);
      hi_cycle(2, "R7 gate lag 2");
      hold(10);
      lo_cycle(8, "R5 node fall");
      hold(10);
      hi_cycle(1, "R7 gate lag 1");
      hold(10);
      lo_cycle(16, "R6 timeout edge");
      hold(10);
      hi_cycle(0, "R7 again");
      hold(10);
      lo_cycle(30, "R6 node stuck high");
      hold(10);
      hi_cycle(0, "R7 before abort");
      hold(10);

      // R8: PWM rises again during the low-side wait
      @(negedge clk) pwm_in = 1'b0;
      w = 0;
      while (hs_en && w < 10) begin @(negedge clk); w++; end
      sw_low = 1'b0;
      gap = 0;
      other = 1'b0;
      while (!hs_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (ls_en) other = 1'b1;
         if (gap == 5) pwm_in = 1'b1;
      end
      sw_low = 1'b1;
      chk("R8 abort to high gap", gap, 5 + 4 + DLY);
      chk("R8 ls stayed off", int'(other), 0);
      hold(10);
      lo_cycle(0, "R4 after abort");
      hold(10);

      // R8: PWM falls again during the high-side wait
      @(negedge clk) pwm_in = 1'b1;
      w = 0;
      while (ls_en && w < 10) begin @(negedge clk); w++; end
      gap = 0;
      other = 1'b0;
      while (!ls_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (hs_en) other = 1'b1;
         if (gap == 4) pwm_in = 1'b0;
      end
      chk("R8 abort to low gap", gap, 4 + 18);
      chk("R8 hs stayed off", int'(other), 0);
      hold(10);
      hi_cycle(0, "R7 before disable");
      hold(10);

      // R2 and R9: disable and release
      @(negedge clk) out_en_n = 1'b0;
      #1;
      chk("R2 hs forced low", int'(hs_en), 0);
      chk("R2 ls forced low", int'(ls_en), 0);
      @(negedge clk) pwm_in = 1'b0;
      hold(8);
      chk("R2 ls held low with pwm low", int'(ls_en), 0);
      pwm_in = 1'b1;
      hold(6);
      chk("R2 hs held low with pwm high", int'(hs_en), 0);
      @(negedge clk) out_en_n = 1'b1;
      gap = 0;
      other = 1'b0;
      while (!hs_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (ls_en) other = 1'b1;
      end
      chk("R9 release high gap", gap, 4 + DLY);
      chk("R9 ls off on high release", int'(other), 0);
      hold(5);
      @(negedge clk) out_en_n = 1'b0;
      pwm_in = 1'b0;
      hold(8);
      @(negedge clk) out_en_n = 1'b1;
      gap = 0;
      other = 1'b0;
      while (!ls_en && gap < 60) begin
         @(negedge clk);
         gap++;
         if (hs_en) other = 1'b1;
      end
      chk("R9 release low gap", gap, 18);
      chk("R9 hs off on low release", int'(other), 0);
      lsg_low = 1'b0;
      hold(10);

      // random cycles
      for (int i = 0; i < 24; i++) begin
         int h, l;
         l = $urandom_range(0, 8);
         h = $urandom_range(0, 24);
         hi_cycle(l, "R7 random");
         hold($urandom_range(6, 30));
         chk("R1 random hs", int'(hs_en), 1);
         lo_cycle(h, (h == 0) ? "R4 random" : ((h + 3 >= TO) ? "R6 random" : "R5 random"));
         hold($urandom_range(6, 30));
         chk("R1 random ls", int'(ls_en), 1);
      end

      finish_run();
   end

endmodule